// File: doc/BRIEF.md
# Vector Prefix Loop Sequencer

This block sits between instruction fetch and register access in a small scalar core that also accepts a 64-bit prefixed vector form. It owns the program counter. On every cycle it looks at the word at the current PC and at the word that follows it, and decides whether the first word is a vector prefix. For a prefix it gathers the 24-bit remap field and hands the following word (the suffix) onward as the operation to execute. For an ordinary word it hands that word onward and drives the remap field to zero, so downstream logic sees a scalar instruction.

A 32-bit loop state register holds the maximum vector length, the vector length (VL), a source step, a destination step and two sub-vector fields. For every source operand and for the destination, the decoder supplies a base register number and a vector flag. Inside a prefixed instruction a vector operand is mapped to base plus the current source step, modulo 32. While the destination is a vector and elements remain, the PC is frozen and the step counts up, one element per clock. When the last element (step VL-1) issues, or when the destination is scalar, the step returns to 0 and the PC moves on by 8 for a prefixed instruction or by 4 for an ordinary one.

Software loads the state register through a dedicated write port. A write cycle issues nothing: the PC and the loop stand still and the new state governs the next cycle.

Top module: `vps_sequencer`

## Requirements
- R1: A fetched word w is a vector prefix exactly when w[31:26] == 6'b000001, w[24] == 1 and w[22] == 1 (LSB0 numbering).
- R2: For a prefix, remap_o = {w[25], w[23], w[21:0]}; for any other word, remap_o is zero.
- R3: fetch_sfx_addr_o equals fetch_pc_o + 4; op_word_o is the word at fetch_pc_o + 4 for a prefixed instruction and the word at fetch_pc_o otherwise.
- R4: The state register layout is: max length [31:25], VL [24:18], source step [17:11], destination step [10:4], sub-vector length [3:2], sub-step [1:0]; the loop changes only the source step.
- R5: In a prefixed instruction, an operand whose vector flag is set gets register number (base + source step) mod 32; every other operand gets its base number.
- R6: For a prefixed instruction with a vector destination and source step not equal to VL-1, the next cycle has the same PC and the source step plus one.
- R7: Otherwise (last element, scalar destination or ordinary instruction) the source step becomes 0 and the PC advances by 8 if the instruction was prefixed, by 4 if not.
- R8: When sv_wr_en_i is high, the next cycle sees the state register equal to sv_wr_data_i and the PC unchanged.
- R9: After reset the PC equals RESET_PC (default 0) and the state register is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sv_wr_en_i | input | 1 | Load the loop state register |
| sv_wr_data_i | input | 32 | Value to load |
| fetch_pc_o | output | PC_W | Current PC, address of the first fetched word |
| fetch_sfx_addr_o | output | PC_W | Address of the following word |
| word_i | input | 32 | Word fetched at fetch_pc_o |
| sfx_word_i | input | 32 | Word fetched at fetch_sfx_addr_o |
| src_base_i | input | NUM_SRC*5 | Decoded source base registers, operand k at [5k+4:5k] |
| src_vec_i | input | NUM_SRC | Vector flag per source operand |
| dst_base_i | input | 5 | Decoded destination base register |
| dst_vec_i | input | 1 | Destination vector flag |
| prefixed_o | output | 1 | Current instruction is prefixed |
| remap_o | output | 24 | Remap field of the current instruction |
| op_word_o | output | 32 | Operation word to execute |
| src_reg_o | output | NUM_SRC*5 | Element source register numbers |
| dst_reg_o | output | 5 | Element destination register number |
| sv_state_o | output | 32 | Current loop state |

## Verification
A wrong step or a wrong hold decision shows at the ports in the very next cycle: the element register numbers repeat or skip, and fetch_pc_o either stalls past the last element or leaves a loop early, so the bench compares every cycle against a reference walk of the program. A wrong prefix decision shows at once as a remap field or operation word taken from the wrong place and, one cycle later, as a PC step of 4 instead of 8 or the reverse. Runs with VL of 1, 3 and 127 and with a scalar destination check the exit cases and register wrap, and a write in the middle of a loop checks that the loaded state takes over without moving the PC.

// File: rtl/vps_pkg.sv
package vps_pkg;

    localparam int WORD_W  = 32;
    localparam int STEP_W  = 7;
    localparam int REG_AW  = 5;
    localparam int REMAP_W = 24;
    localparam int MAJOR_W = 6;
    localparam logic [MAJOR_W-1:0] PREFIX_MAJOR = 6'd1;

    // Loop state, first member sits in the most significant bits
    typedef struct packed {
        logic [STEP_W-1:0] max_len;
        logic [STEP_W-1:0] vec_len;
        logic [STEP_W-1:0] src_step;
        logic [STEP_W-1:0] dst_step;
        logic [1:0]        sub_len;
        logic [1:0]        sub_step;
    } loop_state_t;

    typedef struct packed {
        logic               prefixed;
        logic [REMAP_W-1:0] remap;
        logic [WORD_W-1:0]  op_word;
    } decoded_t;

    function automatic logic is_vec_prefix(input logic [WORD_W-1:0] w);
        return (w[31:26] == PREFIX_MAJOR) && w[24] && w[22];
    endfunction

    function automatic logic [REMAP_W-1:0] gather_remap(input logic [WORD_W-1:0] w);
        return {w[25], w[23], w[21:0]};
    endfunction

    function automatic logic [REG_AW-1:0] elem_reg(input logic [REG_AW-1:0] base,
                                                   input logic [STEP_W-1:0] step);
        logic [STEP_W-1:0] sum;
        sum = {{(STEP_W-REG_AW){1'b0}}, base} + step;
        return sum[REG_AW-1:0];
    endfunction

endpackage

// File: rtl/vps_prefix_decode.sv
module vps_prefix_decode
    import vps_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] word_i,
    input  logic [WORD_W-1:0] sfx_word_i,
    output decoded_t          dec_o
);

    always_comb begin
        dec_o.prefixed = is_vec_prefix(word_i);
        if (dec_o.prefixed) begin
            dec_o.remap   = gather_remap(word_i);
            dec_o.op_word = sfx_word_i;
        end else begin
            dec_o.remap   = '0;
            dec_o.op_word = word_i;
        end
    end

    // R2: an ordinary word never carries a remap field downstream
    a_r2_remap_zero: assert property (@(posedge clk) disable iff (rst)
        !dec_o.prefixed |-> (dec_o.remap == '0));

    // R3: ordinary word passes through unchanged
    a_r3_scalar_pass: assert property (@(posedge clk) disable iff (rst)
        !dec_o.prefixed |-> (dec_o.op_word == word_i));

endmodule

// File: rtl/vps_elem_map.sv
module vps_elem_map
    import vps_pkg::*;
#(
    parameter int NUM_OPS = 3
) (
    input  logic [NUM_OPS*REG_AW-1:0] base_i,
    input  logic [NUM_OPS-1:0]        vec_i,
    input  logic                      prefixed_i,
    input  logic [STEP_W-1:0]         step_i,
    output logic [NUM_OPS*REG_AW-1:0] reg_o
);

    for (genvar k = 0; k < NUM_OPS; k++) begin : g_op
        logic [REG_AW-1:0] base_k;
        assign base_k = base_i[k*REG_AW +: REG_AW];
        assign reg_o[k*REG_AW +: REG_AW] = (prefixed_i && vec_i[k])
                                         ? elem_reg(base_k, step_i)
                                         : base_k;
    end

endmodule

// File: rtl/vps_loop_ctrl.sv
module vps_loop_ctrl
    import vps_pkg::*;
#(
    parameter int              PC_W     = 32,
    parameter logic [PC_W-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  logic [WORD_W-1:0] wr_data_i,
    input  logic              prefixed_i,
    input  logic              dst_vec_i,
    output logic [PC_W-1:0]   pc_o,
    output loop_state_t       state_o
);

    localparam logic [PC_W-1:0] STEP_SHORT = PC_W'(4);
    localparam logic [PC_W-1:0] STEP_LONG  = PC_W'(8);

    logic [PC_W-1:0] pc_q;
    loop_state_t     st_q;
    logic            last_elem;
    logic            stay;
    logic [PC_W-1:0] pc_inc;

    assign last_elem = (st_q.src_step == st_q.vec_len - STEP_W'(1));
    assign stay      = prefixed_i && dst_vec_i && !last_elem;
    assign pc_inc    = prefixed_i ? STEP_LONG : STEP_SHORT;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= RESET_PC;
            st_q <= '0;
        end else if (wr_en_i) begin
            st_q <= loop_state_t'(wr_data_i);
        end else if (stay) begin
            st_q.src_step <= st_q.src_step + STEP_W'(1);
        end else begin
            st_q.src_step <= '0;
            pc_q          <= pc_q + pc_inc;
        end
    end

    assign pc_o    = pc_q;
    assign state_o = st_q;

    // R6: elements remain, so the PC holds and the step moves on
    a_r6_hold_pc: assert property (@(posedge clk) disable iff (rst)
        (!wr_en_i && prefixed_i && dst_vec_i && !last_elem)
        |=> (pc_q == $past(pc_q)) && (st_q.src_step == $past(st_q.src_step) + STEP_W'(1)));

    // R7: loop end, step cleared and PC advanced by instruction length
    a_r7_end_advance: assert property (@(posedge clk) disable iff (rst)
        (!wr_en_i && !stay)
        |=> (st_q.src_step == '0) && (pc_q == $past(pc_q) + $past(pc_inc)));

    // R4: loop activity never disturbs fields other than the source step
    a_r4_other_fields: assert property (@(posedge clk) disable iff (rst)
        !wr_en_i |=> (st_q.vec_len == $past(st_q.vec_len)) && (st_q.max_len == $past(st_q.max_len))
                   && (st_q.dst_step == $past(st_q.dst_step)) && $stable(st_q.sub_len)
                   && $stable(st_q.sub_step));

    // R8: a write loads the state and freezes the PC
    a_r8_write_loads: assert property (@(posedge clk) disable iff (rst)
        wr_en_i |=> (st_q == loop_state_t'($past(wr_data_i))) && (pc_q == $past(pc_q)));

endmodule

// File: rtl/vps_sequencer.sv
module vps_sequencer
    import vps_pkg::*;
#(
    parameter int              PC_W     = 32,
    parameter int              NUM_SRC  = 3,
    parameter logic [PC_W-1:0] RESET_PC = '0
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      sv_wr_en_i,
    input  logic [31:0]               sv_wr_data_i,
    output logic [PC_W-1:0]           fetch_pc_o,
    output logic [PC_W-1:0]           fetch_sfx_addr_o,
    input  logic [31:0]               word_i,
    input  logic [31:0]               sfx_word_i,
    input  logic [NUM_SRC*5-1:0]      src_base_i,
    input  logic [NUM_SRC-1:0]        src_vec_i,
    input  logic [4:0]                dst_base_i,
    input  logic                      dst_vec_i,
    output logic                      prefixed_o,
    output logic [23:0]               remap_o,
    output logic [31:0]               op_word_o,
    output logic [NUM_SRC*5-1:0]      src_reg_o,
    output logic [4:0]                dst_reg_o,
    output logic [31:0]               sv_state_o
);

    decoded_t        dec;
    loop_state_t     state;
    logic [PC_W-1:0] pc;

    vps_prefix_decode u_decode (
        .clk       (clk),
        .rst       (rst),
        .word_i    (word_i),
        .sfx_word_i(sfx_word_i),
        .dec_o     (dec)
    );

    vps_loop_ctrl #(
        .PC_W    (PC_W),
        .RESET_PC(RESET_PC)
    ) u_loop (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (sv_wr_en_i),
        .wr_data_i (sv_wr_data_i),
        .prefixed_i(dec.prefixed),
        .dst_vec_i (dst_vec_i),
        .pc_o      (pc),
        .state_o   (state)
    );

    vps_elem_map #(.NUM_OPS(NUM_SRC)) u_src_map (
        .base_i    (src_base_i),
        .vec_i     (src_vec_i),
        .prefixed_i(dec.prefixed),
        .step_i    (state.src_step),
        .reg_o     (src_reg_o)
    );

    vps_elem_map #(.NUM_OPS(1)) u_dst_map (
        .base_i    (dst_base_i),
        .vec_i     (dst_vec_i),
        .prefixed_i(dec.prefixed),
        .step_i    (state.src_step),
        .reg_o     (dst_reg_o)
    );

    assign fetch_pc_o       = pc;
    assign fetch_sfx_addr_o = pc + PC_W'(4);
    assign prefixed_o       = dec.prefixed;
    assign remap_o          = dec.remap;
    assign op_word_o        = dec.op_word;
    assign sv_state_o       = state;

    // R5: a scalar destination keeps its decoded number
    a_r5_scalar_dst: assert property (@(posedge clk) disable iff (rst)
        !dst_vec_i |-> (dst_reg_o == dst_base_i));

endmodule

// File: tb/vps_sequencer_tb.sv
module vps_sequencer_tb;

    localparam int NS = 3;

    typedef struct {
        logic [31:0]   pc;
        logic          pref;
        logic [23:0]   remap;
        logic [31:0]   op;
        logic [4:0]    dst;
        logic [14:0]   src;
        logic [6:0]    step;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sv_wr_en = 1'b0;
    logic [31:0] sv_wr_data = '0;
    logic [31:0] fetch_pc, fetch_sfx;
    logic [31:0] word, sfx_word;
    logic [NS*5-1:0] src_base;
    logic [NS-1:0] src_vec;
    logic [4:0] dst_base;
    logic dst_vec;
    logic prefixed;
    logic [23:0] remap;
    logic [31:0] op_word;
    logic [NS*5-1:0] src_reg;
    logic [4:0] dst_reg;
    logic [31:0] sv_state;

    logic [31:0] mem [64];
    exp_t q[$];
    int checks = 0;
    int errors = 0;
    logic [31:0] m_pc;
    logic [6:0]  m_step, m_vl;

    always #5 clk = ~clk;

    assign word     = mem[fetch_pc[7:2]];
    assign sfx_word = mem[fetch_sfx[7:2]];

    vps_sequencer #(.PC_W(32), .NUM_SRC(NS)) u_dut (
        .clk(clk), .rst(rst),
        .sv_wr_en_i(sv_wr_en), .sv_wr_data_i(sv_wr_data),
        .fetch_pc_o(fetch_pc), .fetch_sfx_addr_o(fetch_sfx),
        .word_i(word), .sfx_word_i(sfx_word),
        .src_base_i(src_base), .src_vec_i(src_vec),
        .dst_base_i(dst_base), .dst_vec_i(dst_vec),
        .prefixed_o(prefixed), .remap_o(remap), .op_word_o(op_word),
        .src_reg_o(src_reg), .dst_reg_o(dst_reg), .sv_state_o(sv_state)
    );

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Scoreboard monitor: compares one expected item per cycle, mid-cycle
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk(fetch_pc == e.pc, "R6/R7 pc", fetch_pc, e.pc);
            chk(fetch_sfx == e.pc + 32'd4, "R3 suffix address", fetch_sfx, e.pc + 32'd4);
            chk(prefixed == e.pref, "R1 prefix detect", {31'd0, prefixed}, {31'd0, e.pref});
            chk(remap == e.remap, "R2 remap", {8'd0, remap}, {8'd0, e.remap});
            chk(op_word == e.op, "R3 op word", op_word, e.op);
            chk(dst_reg == e.dst, "R5 dst reg", {27'd0, dst_reg}, {27'd0, e.dst});
            chk(src_reg == e.src, "R5 src regs", {17'd0, src_reg}, {17'd0, e.src});
            chk(sv_state[17:11] == e.step, "R4 step field", {25'd0, sv_state[17:11]}, {25'd0, e.step});
        end
    end

    // Driver: reference walk of the program, one element per cycle
    task automatic run_cycles(input int n);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            logic [31:0] w;
            logic pf;
            w  = mem[m_pc[7:2]];
            pf = (w[31:26] == 6'b000001) && w[24] && w[22];
            e.pc    = m_pc;
            e.pref  = pf;
            e.remap = pf ? {w[25], w[23], w[21:0]} : 24'd0;
            e.op    = pf ? mem[m_pc[7:2] + 6'd1] : w;
            e.dst   = (pf && dst_vec) ? dst_base + m_step[4:0] : dst_base;
            for (int k = 0; k < NS; k++) begin
                logic [4:0] b;
                b = src_base[k*5 +: 5];
                e.src[k*5 +: 5] = (pf && src_vec[k]) ? b + m_step[4:0] : b;
            end
            e.step = m_step;
            q.push_back(e);
            @(posedge clk);
            #1;
            if (pf && dst_vec && (m_step != m_vl - 7'd1)) begin
                m_step = m_step + 7'd1;
            end else begin
                m_step = '0;
                m_pc   = m_pc + (pf ? 32'd8 : 32'd4);
            end
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(posedge clk); @(posedge clk);
        #1;
        rst = 1'b0;
        m_pc = '0;
        m_step = '0;
        m_vl = '0;
        chk(fetch_pc == 32'd0, "R9 reset pc", fetch_pc, 32'd0);
        chk(sv_state == 32'd0, "R9 reset state", sv_state, 32'd0);
    endtask

    task automatic write_state(input logic [31:0] d);
        logic [31:0] pc_before;
        pc_before = fetch_pc;
        sv_wr_en = 1'b1;
        sv_wr_data = d;
        @(posedge clk);
        #1;
        sv_wr_en = 1'b0;
        m_step = d[17:11];
        m_vl = d[24:18];
        chk(sv_state == d, "R8 state loaded", sv_state, d);
        chk(fetch_pc == pc_before, "R8 pc held on write", fetch_pc, pc_before);
    endtask

    function automatic logic [31:0] mk_state(input logic [6:0] mx, input logic [6:0] vl,
                                             input logic [6:0] ss, input logic [6:0] ds,
                                             input logic [1:0] sl, input logic [1:0] sst);
        return {mx, vl, ss, ds, sl, sst};
    endfunction

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 32'h7C00_0214;
        mem[1] = 32'h0741_2345;   // prefix, remap bits 25/23 = 1/0
        mem[2] = 32'h3860_0001;   // suffix
        mem[3] = 32'h7C22_1A14;
        mem[4] = 32'h05C0_0007;   // prefix, remap bits 25/23 = 0/1
        mem[5] = 32'h3880_0002;   // suffix
        mem[6] = 32'h0501_2345;   // major 1 but bit 22 clear: ordinary (R1)
        mem[7] = 32'h7C00_0214;
        src_base = {5'd31, 5'd10, 5'd3};
        src_vec  = 3'b101;
        dst_base = 5'd30;
        dst_vec  = 1'b1;

        // VL = 3 with vector destination, register wrap past 31 (R5, R6, R7)
        do_reset();
        write_state(mk_state(7'd8, 7'd3, 7'd0, 7'd5, 2'd2, 2'd1));
        run_cycles(10);
        #4;
        chk(fetch_pc == 32'd32, "R7 pc after VL=3 program", fetch_pc, 32'd32);
        chk(sv_state == mk_state(7'd8, 7'd3, 7'd0, 7'd5, 2'd2, 2'd1), "R4 other fields kept",
            sv_state, mk_state(7'd8, 7'd3, 7'd0, 7'd5, 2'd2, 2'd1));

        // Scalar destination ends after one pass (R7)
        do_reset();
        dst_vec = 1'b0;
        write_state(mk_state(7'd8, 7'd3, 7'd0, 7'd0, 2'd0, 2'd0));
        run_cycles(6);
        #4;
        chk(fetch_pc == 32'd32, "R7 pc scalar destination", fetch_pc, 32'd32);

        // VL = 1
        do_reset();
        dst_vec = 1'b1;
        write_state(mk_state(7'd1, 7'd1, 7'd0, 7'd0, 2'd0, 2'd0));
        run_cycles(6);
        #4;
        chk(fetch_pc == 32'd32, "R7 pc VL=1", fetch_pc, 32'd32);

        // VL at its maximum
        do_reset();
        write_state(mk_state(7'd127, 7'd127, 7'd0, 7'd0, 2'd0, 2'd0));
        run_cycles(129);
        #4;
        chk(fetch_pc == 32'd16, "R6 pc VL=127", fetch_pc, 32'd16);

        // Write in the middle of a loop (R8)
        do_reset();
        write_state(mk_state(7'd8, 7'd3, 7'd0, 7'd0, 2'd0, 2'd0));
        run_cycles(2);
        #4;
        write_state(mk_state(7'd8, 7'd2, 7'd0, 7'd0, 2'd0, 2'd0));
        run_cycles(3);
        #4;
        chk(fetch_pc == 32'd16, "R8 pc after reloaded loop", fetch_pc, 32'd16);

        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule